// File: doc/BRIEF.md
# Page Access Permission and Fault Encoder

This unit sits after the segment and page lookups of a hashed-page memory management unit and decides whether one access may proceed. For each strobed request it takes the access kind, the privilege state, the fields of the matching segment descriptor and of the page table entry, the per-key authority mask and the two translation-enable bits. From these it produces the granted rights and, when the access may not proceed, a fault with its exception class, error code, status word and fault address.

Rights come from two sources that are ANDed together. The first is a 3-bit protection code interpreted under a key chosen by privilege. The second is an optional 2-bit field taken from a wide authority mask and indexed by the page's key. When translation is disabled for the access kind, the lookup is bypassed. Full rights are then granted and the real address is formed directly. All results are registered on the request strobe and are held until the next strobe.

Top module: `page_guard`

## Requirements
- R1: Access kind is 0 read, 1 write, 2 fetch, and 3 is treated as a read. A fetch is bypassed when `xlate_ifetch_en` is 0, and a data access is bypassed when `xlate_data_en` is 0. A bypassed access has rights 3'b111, no fault and `real_addr` equal to the effective address with its top 4 bits cleared. A translated access has `real_addr` 0.
- R2: Rights bits are bit0 read, bit1 write, bit2 execute. The key is `seg_key_user` when `priv_user` is 1 and `seg_key_super` otherwise. The protection code is {`pte_pp_hi`, `pte_pp_lo`}. Under key 0, codes 0, 1 and 2 give read and write, codes 3 and 6 give read only, and codes 4, 5 and 7 give neither.
- R3: Under key 1, codes 1 and 3 give read only, code 2 gives read and write, and codes 0, 4, 5, 6 and 7 give neither.
- R4: Page execute is granted when `pte_noexec` is 0, or when `pte_guard` is 1, or when `seg_noexec` is 1.
- R5: With `mask_en` 1, the page key k selects mask bits [2*(NUM_KEYS-1-k)+1 : 2*(NUM_KEYS-1-k)]. The upper bit of that pair grants write and the lower bit grants read, and execute is always granted. With `mask_en` 0 the mask grants all rights. The reported rights are the protection rights ANDed with the mask rights, and this holds on a permission fault as well.
- R6: Exception classes are 0 none, 1 instruction segment miss, 2 data segment miss, 3 instruction storage, 4 data storage. A translated access with `seg_hit` 0 faults with class 1 for a fetch and class 2 otherwise. Its error code and status are 0. A data fault of any class sets `fault_addr` to the effective address. Every other result has `fault_addr` 0.
- R7: A translated fetch from a segment with `seg_noexec` 1 faults with class 3 and error code 0x10000000. This check comes before the page-presence check.
- R8: With `pte_found` 0, a fetch faults with class 3 and error code 0x40000000. A data access faults with class 4 and status 0x42000000 for a write or 0x40000000 for a read.
- R9: A data access that lacks its needed right faults with class 4 and error code 0. Its status is the OR of three terms: 0x08000000 if the protection rights lack the right, 0x02000000 if the access is a write, and 0x00200000 if the mask rights lack the right.
- R10: A fetch that lacks execute faults with class 3, error code 0x08000000 and status 0.
- R11: Outputs load only in a cycle where `req_valid` is 1. `rsp_valid` is high for exactly the one cycle that follows each strobe. Between strobes all other outputs hold their values.
- R12: Reset, synchronous and active high, clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| eff_addr | input | EA_W | Effective address |
| priv_user | input | 1 | 1 = user state, 0 = supervisor state |
| xlate_ifetch_en | input | 1 | Translation enable for fetches |
| xlate_data_en | input | 1 | Translation enable for data accesses |
| seg_hit | input | 1 | A segment descriptor matched |
| seg_key_user | input | 1 | Descriptor key used in user state |
| seg_key_super | input | 1 | Descriptor key used in supervisor state |
| seg_noexec | input | 1 | Segment is marked no-execute |
| pte_found | input | 1 | A page table entry was found |
| pte_pp_hi | input | 1 | High bit of the protection code |
| pte_pp_lo | input | 2 | Low bits of the protection code |
| pte_noexec | input | 1 | Entry no-execute bit |
| pte_guard | input | 1 | Entry guarded bit |
| pte_key | input | $clog2(NUM_KEYS) | Entry key for the authority mask |
| mask_en | input | 1 | Authority mask enabled |
| mask_reg | input | 2*NUM_KEYS | Authority mask |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rights | output | 3 | Granted rights {exec, write, read} |
| fault | output | 1 | Access faulted |
| exc_class | output | 3 | Exception class |
| err_code | output | 32 | Error code of the fault |
| data_status | output | 32 | Status word of a data storage fault |
| fault_addr | output | EA_W | Effective address of a data fault |
| real_addr | output | EA_W | Real address of a bypassed access |

## Verification
The bench builds the block with its default values, EA_W = 64 and NUM_KEYS = 32. With these values the mask is 64 bits wide. Key 0 then selects the top two mask bits and key 31 the bottom two, so both ends of the reversed key indexing are exercised. The 64-bit address makes the clearing of the top 4 bits in bypass visible in the leading nibble.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_ISEG  = 3'd1,
    EXC_DSEG  = 3'd2,
    EXC_ISTOR = 3'd3,
    EXC_DSTOR = 3'd4
  } exc_e;

  localparam int RT_RD = 0;
  localparam int RT_WR = 1;
  localparam int RT_EX = 2;

  localparam logic [31:0] CODE_SEG_NX  = 32'h1000_0000;
  localparam logic [31:0] CODE_NO_PAGE = 32'h4000_0000;
  localparam logic [31:0] CODE_PROT    = 32'h0800_0000;
  localparam logic [31:0] CODE_STORE   = 32'h0200_0000;
  localparam logic [31:0] CODE_KEY     = 32'h0020_0000;
endpackage

// File: rtl/pg_pp_rights.sv
module pg_pp_rights (
  input  logic       key,
  input  logic [2:0] code,
  input  logic       pte_noexec,
  input  logic       pte_guard,
  input  logic       seg_noexec,
  output logic [2:0] rights
);
  logic [1:0] rw;

  always_comb begin
    rw = 2'b00;
    if (!key) begin
      case (code)
        3'd0, 3'd1, 3'd2: rw = 2'b11;
        3'd3, 3'd6:       rw = 2'b01;
        default:          rw = 2'b00;
      endcase
    end else begin
      case (code)
        3'd1, 3'd3: rw = 2'b01;
        3'd2:       rw = 2'b11;
        default:    rw = 2'b00;
      endcase
    end
  end

  // The execute rule deliberately grants on guarded or segment no-execute.
  assign rights = {(!pte_noexec) | pte_guard | seg_noexec, rw};
endmodule

// File: rtl/pg_mask_rights.sv
module pg_mask_rights #(
  parameter int NUM_KEYS = 32,
  localparam int KEY_W  = $clog2(NUM_KEYS),
  localparam int MASK_W = 2 * NUM_KEYS
) (
  input  logic              mask_en,
  input  logic [KEY_W-1:0]  key,
  input  logic [MASK_W-1:0] mask_reg,
  output logic [2:0]        rights
);
  logic [1:0] pair [NUM_KEYS];
  logic [1:0] sel;

  // Key k lives at bit pair 2*(NUM_KEYS-1-k): key 0 is the top pair.
  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_pair
    assign pair[g] = mask_reg[2*(NUM_KEYS-1-g) +: 2];
  end

  always_comb begin
    sel = 2'b00;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (key == KEY_W'(i)) sel = pair[i];
    end
  end

  assign rights = mask_en ? {1'b1, sel[1], sel[0]} : 3'b111;
endmodule

// File: rtl/pg_fault_enc.sv
module pg_fault_enc
  import pg_pkg::*;
#(
  parameter int EA_W = 64
) (
  input  logic            is_fetch,
  input  logic            is_write,
  input  logic            seg_hit,
  input  logic            seg_noexec,
  input  logic            pte_found,
  input  logic [2:0]      pp_rights,
  input  logic [2:0]      mk_rights,
  input  logic [EA_W-1:0] ea,
  output logic            fault,
  output exc_e            exc,
  output logic [31:0]     err,
  output logic [31:0]     status,
  output logic [EA_W-1:0] addr,
  output logic [2:0]      rights
);
  logic [2:0] need;
  logic       pp_miss, mk_miss;

  always_comb begin
    need = 3'b000;
    if (is_fetch)      need[RT_EX] = 1'b1;
    else if (is_write) need[RT_WR] = 1'b1;
    else               need[RT_RD] = 1'b1;
  end

  assign pp_miss = |(need & ~pp_rights);
  assign mk_miss = |(need & ~mk_rights);

  always_comb begin
    fault  = 1'b0;
    exc    = EXC_NONE;
    err    = '0;
    status = '0;
    addr   = '0;
    rights = 3'b000;
    if (!seg_hit) begin
      fault = 1'b1;
      if (is_fetch) exc = EXC_ISEG;
      else begin
        exc  = EXC_DSEG;
        addr = ea;
      end
    end else if (is_fetch && seg_noexec) begin
      fault = 1'b1;
      exc   = EXC_ISTOR;
      err   = CODE_SEG_NX;
    end else if (!pte_found) begin
      fault = 1'b1;
      if (is_fetch) begin
        exc = EXC_ISTOR;
        err = CODE_NO_PAGE;
      end else begin
        exc    = EXC_DSTOR;
        status = is_write ? (CODE_NO_PAGE | CODE_STORE) : CODE_NO_PAGE;
        addr   = ea;
      end
    end else begin
      rights = pp_rights & mk_rights;
      if (pp_miss || mk_miss) begin
        fault = 1'b1;
        if (is_fetch) begin
          exc = EXC_ISTOR;
          err = CODE_PROT;
        end else begin
          exc    = EXC_DSTOR;
          status = (pp_miss ? CODE_PROT : 32'h0) | (is_write ? CODE_STORE : 32'h0)
                 | (mk_miss ? CODE_KEY : 32'h0);
          addr   = ea;
        end
      end
    end
  end
endmodule

// File: rtl/page_guard.sv
module page_guard
  import pg_pkg::*;
#(
  parameter int EA_W     = 64,
  parameter int NUM_KEYS = 32,
  localparam int KEY_W  = $clog2(NUM_KEYS),
  localparam int MASK_W = 2 * NUM_KEYS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [EA_W-1:0]   eff_addr,
  input  logic              priv_user,
  input  logic              xlate_ifetch_en,
  input  logic              xlate_data_en,
  input  logic              seg_hit,
  input  logic              seg_key_user,
  input  logic              seg_key_super,
  input  logic              seg_noexec,
  input  logic              pte_found,
  input  logic              pte_pp_hi,
  input  logic [1:0]        pte_pp_lo,
  input  logic              pte_noexec,
  input  logic              pte_guard,
  input  logic [KEY_W-1:0]  pte_key,
  input  logic              mask_en,
  input  logic [MASK_W-1:0] mask_reg,
  output logic              rsp_valid,
  output logic [2:0]        rights,
  output logic              fault,
  output logic [2:0]        exc_class,
  output logic [31:0]       err_code,
  output logic [31:0]       data_status,
  output logic [EA_W-1:0]   fault_addr,
  output logic [EA_W-1:0]   real_addr
);
  logic            is_fetch, is_write, bypass, sel_key;
  logic [2:0]      pp_r, mk_r, enc_rights;
  logic            enc_fault;
  exc_e            enc_exc;
  logic [31:0]     enc_err, enc_status;
  logic [EA_W-1:0] enc_addr, bypass_addr;

  assign is_fetch    = (req_kind == 2'd2);
  assign is_write    = (req_kind == 2'd1);
  assign bypass      = is_fetch ? !xlate_ifetch_en : !xlate_data_en;
  assign sel_key     = priv_user ? seg_key_user : seg_key_super;
  assign bypass_addr = {4'b0000, eff_addr[EA_W-5:0]};

  pg_pp_rights i_pp (
    .key        (sel_key),
    .code       ({pte_pp_hi, pte_pp_lo}),
    .pte_noexec (pte_noexec),
    .pte_guard  (pte_guard),
    .seg_noexec (seg_noexec),
    .rights     (pp_r)
  );

  pg_mask_rights #(.NUM_KEYS(NUM_KEYS)) i_mask (
    .mask_en  (mask_en),
    .key      (pte_key),
    .mask_reg (mask_reg),
    .rights   (mk_r)
  );

  pg_fault_enc #(.EA_W(EA_W)) i_enc (
    .is_fetch   (is_fetch),
    .is_write   (is_write),
    .seg_hit    (seg_hit),
    .seg_noexec (seg_noexec),
    .pte_found  (pte_found),
    .pp_rights  (pp_r),
    .mk_rights  (mk_r),
    .ea         (eff_addr),
    .fault      (enc_fault),
    .exc        (enc_exc),
    .err        (enc_err),
    .status     (enc_status),
    .addr       (enc_addr),
    .rights     (enc_rights)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rights      <= '0;
      fault       <= 1'b0;
      exc_class   <= EXC_NONE;
      err_code    <= '0;
      data_status <= '0;
      fault_addr  <= '0;
      real_addr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (bypass) begin
          rights      <= 3'b111;
          fault       <= 1'b0;
          exc_class   <= EXC_NONE;
          err_code    <= '0;
          data_status <= '0;
          fault_addr  <= '0;
          real_addr   <= bypass_addr;
        end else begin
          rights      <= enc_rights;
          fault       <= enc_fault;
          exc_class   <= enc_exc;
          err_code    <= enc_err;
          data_status <= enc_status;
          fault_addr  <= enc_addr;
          real_addr   <= '0;
        end
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R11
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R11
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(exc_class) && $stable(err_code) && $stable(rights)
                   && $stable(fault_addr)); // R11
  AST_BYPASS_FULL_RIGHTS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bypass) |=> (rights == 3'b111) && !fault); // R1
  AST_FAULT_HAS_CLASS: assert property (@(posedge clk) disable iff (rst)
    fault == (exc_class != EXC_NONE)); // R6
  AST_FETCH_FAULT_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    (exc_class == EXC_ISTOR || exc_class == EXC_ISEG) |-> data_status == 32'h0); // R10
endmodule

// File: tb/test_page_guard.sv
module test_page_guard;
  localparam int EA_W = 64;
  localparam int NUM_KEYS = 32;
  localparam int KEY_W = $clog2(NUM_KEYS);

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [1:0]        req_kind;
  logic [EA_W-1:0]   eff_addr;
  logic              priv_user, xlate_ifetch_en, xlate_data_en;
  logic              seg_hit, seg_key_user, seg_key_super, seg_noexec;
  logic              pte_found, pte_pp_hi;
  logic [1:0]        pte_pp_lo;
  logic              pte_noexec, pte_guard;
  logic [KEY_W-1:0]  pte_key;
  logic              mask_en;
  logic [2*NUM_KEYS-1:0] mask_reg;
  logic              rsp_valid, fault;
  logic [2:0]        rights, exc_class;
  logic [31:0]       err_code, data_status;
  logic [EA_W-1:0]   fault_addr, real_addr;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  page_guard #(.EA_W(EA_W), .NUM_KEYS(NUM_KEYS)) i_page_guard (
    .clk, .rst, .req_valid, .req_kind, .eff_addr, .priv_user,
    .xlate_ifetch_en, .xlate_data_en, .seg_hit, .seg_key_user, .seg_key_super,
    .seg_noexec, .pte_found, .pte_pp_hi, .pte_pp_lo, .pte_noexec, .pte_guard,
    .pte_key, .mask_en, .mask_reg, .rsp_valid, .rights, .fault, .exc_class,
    .err_code, .data_status, .fault_addr, .real_addr
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    req_kind = 2'd0; eff_addr = 64'hF123_4567_89AB_CDE0; priv_user = 1'b0;
    xlate_ifetch_en = 1'b1; xlate_data_en = 1'b1;
    seg_hit = 1'b1; seg_key_user = 1'b0; seg_key_super = 1'b0; seg_noexec = 1'b0;
    pte_found = 1'b1; pte_pp_hi = 1'b0; pte_pp_lo = 2'd2;
    pte_noexec = 1'b0; pte_guard = 1'b0; pte_key = '0;
    mask_en = 1'b0; mask_reg = '0;
  endtask

  // Strobe one cycle; outputs are registered at the following edge and read at the next negedge.
  task automatic fire();
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic set_code(int c);
    pte_pp_hi = c[2]; pte_pp_lo = c[1:0];
  endtask

  task automatic t_reset();
    check("R12 rsp_valid", 64'(rsp_valid), 0);
    check("R12 rights", 64'(rights), 0);
    check("R12 fault", 64'(fault), 0);
    check("R12 class", 64'(exc_class), 0);
    check("R12 real_addr", real_addr, 0);
  endtask

  task automatic t_bypass();
    defaults(); req_kind = 2'd2; xlate_ifetch_en = 1'b0; seg_hit = 1'b0; fire();
    check("R1 fetch bypass rights", 64'(rights), 7);
    check("R1 fetch bypass fault", 64'(fault), 0);
    check("R1 fetch bypass addr", real_addr, 64'h0123_4567_89AB_CDE0);
    check("R11 rsp_valid after strobe", 64'(rsp_valid), 1);
    defaults(); req_kind = 2'd1; xlate_data_en = 1'b0; seg_hit = 1'b0; fire();
    check("R1 data bypass rights", 64'(rights), 7);
    check("R1 data bypass fault", 64'(fault), 0);
    defaults(); req_kind = 2'd2; xlate_data_en = 1'b0; seg_hit = 1'b0; fire();
    check("R1 fetch uses fetch enable", 64'(exc_class), 1);
    check("R1 translated real_addr", real_addr, 0);
  endtask

  task automatic t_seg_miss();
    defaults(); req_kind = 2'd2; seg_hit = 1'b0; fire();
    check("R6 fetch seg miss class", 64'(exc_class), 1);
    check("R6 fetch seg miss err", 64'(err_code), 0);
    check("R6 fetch seg miss addr", fault_addr, 0);
    defaults(); req_kind = 2'd3; seg_hit = 1'b0; fire();
    check("R6 data seg miss class", 64'(exc_class), 2);
    check("R6 data seg miss addr", fault_addr, 64'hF123_4567_89AB_CDE0);
  endtask

  task automatic t_seg_nx();
    defaults(); req_kind = 2'd2; seg_noexec = 1'b1; pte_found = 1'b0; fire();
    check("R7 nx class", 64'(exc_class), 3);
    check("R7 nx err", 64'(err_code), 64'h1000_0000);
  endtask

  task automatic t_no_page();
    defaults(); req_kind = 2'd2; pte_found = 1'b0; fire();
    check("R8 fetch no page class", 64'(exc_class), 3);
    check("R8 fetch no page err", 64'(err_code), 64'h4000_0000);
    defaults(); req_kind = 2'd1; pte_found = 1'b0; fire();
    check("R8 write no page class", 64'(exc_class), 4);
    check("R8 write no page status", 64'(data_status), 64'h4200_0000);
    check("R8 write no page addr", fault_addr, 64'hF123_4567_89AB_CDE0);
    defaults(); req_kind = 2'd0; pte_found = 1'b0; fire();
    check("R8 read no page status", 64'(data_status), 64'h4000_0000);
  endtask

  task automatic t_key0();
    logic [2:0] exp [8] = '{3'b111, 3'b111, 3'b111, 3'b101, 3'b100, 3'b100, 3'b101, 3'b100};
    for (int c = 0; c < 8; c++) begin
      defaults(); set_code(c); fire();
      check($sformatf("R2 key0 code %0d", c), 64'(rights), 64'(exp[c]));
    end
    defaults(); priv_user = 1'b1; seg_key_user = 1'b1; set_code(0); fire();
    check("R2 user selects user key", 64'(rights), 3'b100);
    defaults(); priv_user = 1'b0; seg_key_user = 1'b1; set_code(0); fire();
    check("R2 super ignores user key", 64'(rights), 3'b111);
  endtask

  task automatic t_key1();
    logic [2:0] exp [8] = '{3'b100, 3'b101, 3'b111, 3'b101, 3'b100, 3'b100, 3'b100, 3'b100};
    for (int c = 0; c < 8; c++) begin
      defaults(); seg_key_super = 1'b1; set_code(c); fire();
      check($sformatf("R3 key1 code %0d", c), 64'(rights), 64'(exp[c]));
    end
  endtask

  task automatic t_exec();
    defaults(); pte_noexec = 1'b1; fire();
    check("R4 noexec denies", 64'(rights), 3'b011);
    defaults(); pte_noexec = 1'b1; pte_guard = 1'b1; fire();
    check("R4 guard grants", 64'(rights), 3'b111);
    defaults(); pte_noexec = 1'b1; seg_noexec = 1'b1; fire();
    check("R4 seg noexec grants", 64'(rights), 3'b111);
  endtask

  task automatic t_mask();
    defaults(); mask_en = 1'b1; mask_reg = 64'h8000_0000_0000_0000; fire();
    check("R5 key0 top pair write only", 64'(rights), 3'b110);
    check("R9 mask-only read fault", 64'(data_status), 64'h0020_0000);
    check("R9 data perm err", 64'(err_code), 0);
    defaults(); mask_en = 1'b1; pte_key = 5'd31; mask_reg = 64'h1; fire();
    check("R5 key31 bottom pair read only", 64'(rights), 3'b101);
    check("R5 key31 no fault", 64'(fault), 0);
    defaults(); mask_en = 1'b0; mask_reg = 64'h0; fire();
    check("R5 mask disabled", 64'(rights), 3'b111);
  endtask

  task automatic t_data_perm();
    defaults(); req_kind = 2'd1; set_code(3); mask_en = 1'b1;
    mask_reg = 64'h4000_0000_0000_0000; fire();
    check("R9 both fail write status", 64'(data_status), 64'h0A20_0000);
    check("R9 class", 64'(exc_class), 4);
    check("R9 addr", fault_addr, 64'hF123_4567_89AB_CDE0);
    defaults(); req_kind = 2'd1; set_code(3); fire();
    check("R9 pp fail write status", 64'(data_status), 64'h0A00_0000);
  endtask

  task automatic t_fetch_perm();
    defaults(); req_kind = 2'd2; pte_noexec = 1'b1; fire();
    check("R10 class", 64'(exc_class), 3);
    check("R10 err", 64'(err_code), 64'h0800_0000);
    check("R10 status", 64'(data_status), 0);
  endtask

  task automatic t_hold();
    defaults(); req_kind = 2'd1; pte_found = 1'b0; fire();
    seg_hit = 1'b0; req_kind = 2'd2; eff_addr = '0;
    repeat (3) @(negedge clk);
    check("R11 rsp_valid drops", 64'(rsp_valid), 0);
    check("R11 class held", 64'(exc_class), 4);
    check("R11 status held", 64'(data_status), 64'h4200_0000);
    check("R11 addr held", fault_addr, 64'hF123_4567_89AB_CDE0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_seg_miss();
    t_seg_nx();
    t_no_page();
    t_key0();
    t_key1();
    t_exec();
    t_mask();
    t_data_perm();
    t_fetch_perm();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule